// File: doc/BRIEF.md
# Core Timer with Real-Time Interrupt and Watchdog

This block is a free-running binary divider chain, clocked by the system clock, that serves three timing functions. It sets an overflow flag when the whole chain wraps. It sets a periodic real-time flag whenever a chosen stage near the top of the chain falls from one to zero. It drives a watchdog that requests a reset unless software restarts it often enough. Each flag can raise a shared interrupt request, and each has its own enable bit.

Software reaches the block through a small byte-wide register port with a two-bit address:

- **Control register (address 0):** holds the run bit, the rate field and the two interrupt enables.
- **Status / command register (address 1):** shows both flags when read. A write to it acknowledges flags and restarts the watchdog.
- **Count registers (addresses 2 and 3):** the chain value, readable for software timestamps.

Clearing the run bit freezes the whole block.

Top module: `ctmr_core`

## Requirements
- R1: While the run bit (control bit 0) is 1, the count rises by one on every clock and wraps modulo 2^CNT_W. The count reads back with its low byte at address 2 and its upper bits at address 3.
- R2: While the run bit is 0, the count holds its value, neither flag sets, and the watchdog makes no progress and raises no reset request.
- R3: The rate field (control bits 2:1) selects chain bit TAP_BASE+rate. The real-time flag (status bit 1) sets on the clock edge where that bit falls, so the count is then a multiple of 2^(TAP_BASE+rate+1) and the flag events are that many cycles apart.
- R4: The overflow flag (status bit 0) sets on the clock edge where the count wraps from all ones to zero.
- R5: `irq` is high exactly when (overflow flag AND control bit 3) OR (real-time flag AND control bit 4).
- R6: Writing address 1 with bit 0 at 1 clears the overflow flag, and with bit 1 at 1 clears the real-time flag. A 0 in either bit leaves that flag as it is. A flag event in the same cycle as its acknowledge leaves the flag set.
- R7: The watchdog counts real-time events. On the WDOG_PERIODS-th event (default 4) since the last restart or reset, `wdog_rst` is high for exactly one cycle and the count of events starts again.
- R8: Writing address 1 with bit 2 at 1 restarts the watchdog. An event in that same cycle is not counted.
- R9: After reset:
  - the control register reads 0x01 (running, rate 0, both interrupts disabled);
  - the status register reads 0;
  - the count is 0;
  - `irq` and `wdog_rst` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, counted by the chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status/command, 2 count low, 3 count high |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request from the enabled flags |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong count shows at once at the count registers. It also moves every real-time and overflow flag off its expected count value, which the bench sees at the first event after the fault, at most 2^(TAP_BASE+4) cycles later. A wrong selected stage or a wrong flag state shows within one real-time period, as an event interval or alignment that does not match, or as a flag or `irq` that differs from the written enables. A wrong watchdog event count shows as a `wdog_rst` pulse that comes early, comes late or never comes, measured in cycles from the restart write. It is visible within WDOG_PERIODS real-time periods.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

   // Register address space of the core timer
   localparam int unsigned ADDR_W = 2;
   localparam int unsigned RATE_W = 2;
   localparam int unsigned N_TAPS = 2 ** RATE_W;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_CNTL = 2'd2,
      REG_CNTH = 2'd3
   } ctmr_reg_e;

   // Control register image, bit 0 is the LSB (run)
   typedef struct packed {
      logic              rti_ie;
      logic              ovf_ie;
      logic [RATE_W-1:0] rate;
      logic              run;
   } ctmr_ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctmr_ctrl_t);

   // Flag slots in the status register
   localparam int unsigned FLG_OVF = 0;
   localparam int unsigned FLG_RTI = 1;
   localparam int unsigned N_FLG   = 2;

   // Command bit that restarts the watchdog
   localparam int unsigned CMD_WDCLR = 2;

endpackage

// File: rtl/ctmr_chain.sv
module ctmr_chain
   import ctmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 14,
   parameter int unsigned TAP_BASE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic [CNT_W-1:0]  cnt,
   output logic              ovf_tick,
   output logic              rti_tick
);

   logic [N_TAPS-1:0] tap_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + 1'b1;
      end
   end

   // A tap falls on the next increment when it and every bit below it are ones
   for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
      assign tap_fall[g] = &cnt[TAP_BASE+g:0];
   end

   assign rti_tick = run & tap_fall[rate];
   assign ovf_tick = run & (&cnt);

endmodule

// File: rtl/ctmr_flags.sv
module ctmr_flags #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set,
   input  logic [N_SRC-1:0] ack,
   output logic [N_SRC-1:0] flag
);

   for (genvar g = 0; g < N_SRC; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag[g] <= 1'b0;
         end else if (set[g]) begin
            flag[g] <= 1'b1;
         end else if (ack[g]) begin
            flag[g] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ctmr_wdog.sv
module ctmr_wdog #(
   parameter int unsigned PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic rst_req
);

   localparam int unsigned WD_W = (PERIODS > 1) ? $clog2(PERIODS) : 1;
   localparam logic [WD_W-1:0] LAST = WD_W'(PERIODS - 1);

   logic [WD_W-1:0] seen;
   logic            expire;

   assign expire = tick & ~restart & (seen == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen    <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= expire;
         if (restart || expire) begin
            seen <= '0;
         end else if (tick) begin
            seen <= seen + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
   import ctmr_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CNT_W        = 14,
   parameter int unsigned TAP_BASE     = 10,
   parameter int unsigned WDOG_PERIODS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              wdog_rst
);

   localparam int unsigned EXT_W = 2 * DATA_W;

   // Elaboration-time parameter checks
   if (TAP_BASE + N_TAPS > CNT_W) begin : g_bad_tap
      $error("ctmr_core: highest tap lies beyond the chain");
   end
   if (CNT_W > EXT_W) begin : g_bad_cnt
      $error("ctmr_core: count does not fit two data words");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("ctmr_core: data word narrower than control register");
   end
   if (WDOG_PERIODS < 1) begin : g_bad_wd
      $error("ctmr_core: watchdog needs at least one period");
   end

   ctmr_ctrl_t        ctrl_q;
   logic              run_w;
   logic [CNT_W-1:0]  cnt_w;
   logic [EXT_W-1:0]  cnt_ext;
   logic              ovf_tick;
   logic              rti_tick;
   logic [N_FLG-1:0]  flg_set;
   logic [N_FLG-1:0]  flg_ack;
   logic [N_FLG-1:0]  flg_q;
   logic              cmd_wr;
   logic              wd_restart;

   // Control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         ctrl_q.run <= 1'b1;
      end else if (wr_en && (addr == REG_CTRL)) begin
         ctrl_q <= ctmr_ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   assign run_w      = ctrl_q.run;
   assign cmd_wr     = wr_en && (addr == REG_STAT);
   assign wd_restart = cmd_wr & wr_data[CMD_WDCLR];

   ctmr_chain #(
      .CNT_W    (CNT_W),
      .TAP_BASE (TAP_BASE)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w),
      .rate     (ctrl_q.rate),
      .cnt      (cnt_w),
      .ovf_tick (ovf_tick),
      .rti_tick (rti_tick)
   );

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_OVF] = ovf_tick;
      flg_set[FLG_RTI] = rti_tick;
      flg_ack          = cmd_wr ? wr_data[N_FLG-1:0] : '0;
   end

   ctmr_flags #(
      .N_SRC (N_FLG)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flg_set),
      .ack   (flg_ack),
      .flag  (flg_q)
   );

   ctmr_wdog #(
      .PERIODS (WDOG_PERIODS)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (rti_tick),
      .restart (wd_restart),
      .rst_req (wdog_rst)
   );

   assign irq = (flg_q[FLG_OVF] & ctrl_q.ovf_ie) | (flg_q[FLG_RTI] & ctrl_q.rti_ie);

   // Read mux
   assign cnt_ext = EXT_W'(cnt_w);

   always_comb begin
      case (addr)
         REG_CTRL: rd_data = DATA_W'(ctrl_q);
         REG_STAT: rd_data = DATA_W'(flg_q);
         REG_CNTL: rd_data = cnt_ext[DATA_W-1:0];
         REG_CNTH: rd_data = cnt_ext[EXT_W-1:DATA_W];
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/ctmr_core_chk.sv
module ctmr_core_chk #(
   parameter int unsigned CNT_W    = 14,
   parameter int unsigned TAP_BASE = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic [1:0]       flags,
   input logic             irq,
   input logic             wdog_rst
);

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cnt - $past(cnt)) == CNT_W'(1));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));

   // R2
   idle_wdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !wdog_rst);

   // R3
   rti_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> (cnt[TAP_BASE:0] == '0));

   // R4
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> (cnt == '0));

   // R5
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == 2'b00) |-> !irq);

   // R7
   wdog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> !wdog_rst);

endmodule

bind ctmr_core ctmr_core_chk #(
   .CNT_W    (CNT_W),
   .TAP_BASE (TAP_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run_w),
   .cnt      (cnt_w),
   .flags    (flg_q),
   .irq      (irq),
   .wdog_rst (wdog_rst)
);

// File: tb/ctmr_core_tb.sv
module ctmr_core_tb;

   localparam int CNT_W = 8;
   localparam int TB    = 4;   // tap base of the small configuration

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       irq;
   logic       wdog_rst;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int wd_pulses = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (wdog_rst) wd_pulses <= wd_pulses + 1;
   end

   ctmr_core #(
      .DATA_W       (8),
      .CNT_W        (CNT_W),
      .TAP_BASE     (TB),
      .WDOG_PERIODS (4)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .irq      (irq),
      .wdog_rst (wdog_rst)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_test();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // called just after a falling edge; returns just after the next falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_stat(input int bitn, output bit found);
      logic [7:0] d;
      found = 1'b0;
      for (int i = 0; i < 2000 && !found; i++) begin
         @(negedge clk);
         rd(2'd1, d);
         if (d[bitn]) found = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL timeout: actual %0d expected below %0d cycles", 150000, 150000);
      finish_test();
   end

   initial begin
      logic [7:0] d, c0, c1;
      bit found;
      int t1, e1, e2, per, c, vabs, cyc0, p0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(2'd0, d); check(d == 8'h01, "R9 ctrl", d, 1);
      rd(2'd1, d); check(d == 8'h00, "R9 status", d, 0);
      rd(2'd2, d); check(d == 8'h00, "R9 count", d, 0);
      check(irq == 1'b0, "R9 irq", irq, 0);
      check(wdog_rst == 1'b0, "R9 wdog_rst", wdog_rst, 0);

      // R1 count steps over several spans, including a full wrap
      foreach (per_list[k]) begin
         @(negedge clk);
         rd(2'd2, c0);
         repeat (per_list[k]) @(negedge clk);
         rd(2'd2, c1);
         check(c1 == 8'((int'(c0) + per_list[k]) % 256), "R1 count step", c1, (int'(c0) + per_list[k]) % 256);
      end
      rd(2'd3, d); check(d == 8'h00, "R1 count high", d, 0);

      // R3 sweep over every rate
      for (int s = 0; s < 4; s++) begin
         per = 1 << (TB + s + 1);
         @(negedge clk);
         wr(2'd0, 8'(1 | (s << 1)));
         wr(2'd1, 8'h02);
         wait_stat(1, found);
         t1 = cyc;
         rd(2'd2, d); e1 = d;
         check(found && (e1 % per) == 0, "R3 first event alignment", e1, 0);
         wr(2'd1, 8'h02);
         wait_stat(1, found);
         rd(2'd2, d); e2 = d;
         check(found && (cyc - t1) == per, "R3 event interval", cyc - t1, per);
         check((e2 % per) == 0, "R3 second event alignment", e2, 0);
      end

      // R4 / R5 overflow with its interrupt enabled
      @(negedge clk);
      wr(2'd0, 8'h09);
      wr(2'd1, 8'h03);
      wait_stat(0, found);
      rd(2'd2, d);
      check(found && d == 8'h00, "R4 overflow at zero", d, 0);
      check(irq == 1'b1, "R5 irq from overflow", irq, 1);
      wr(2'd0, 8'h01);
      check(irq == 1'b0, "R5 irq masked", irq, 0);
      // R6 writing zero leaves the flag alone
      wr(2'd1, 8'h00);
      rd(2'd1, d); check(d[0] == 1'b1, "R6 zero write keeps flag", d[0], 1);
      wr(2'd1, 8'h01);
      rd(2'd1, d); check(d[0] == 1'b0, "R6 ack clears overflow", d[0], 0);

      // R5 real-time interrupt, rate 0
      wr(2'd0, 8'h11);
      wr(2'd1, 8'h02);
      wait_stat(1, found);
      check(irq == 1'b1, "R5 irq from real-time", irq, 1);
      rd(2'd2, d); e1 = d;
      wr(2'd1, 8'h02);
      check(irq == 1'b0, "R5 irq after ack", irq, 0);
      // R6 event and ack in the same cycle: set wins
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         rd(2'd2, d);
         if (d == 8'((e1 + 31) % 256)) break;
      end
      wr(2'd1, 8'h02);
      rd(2'd1, d); check(d[1] == 1'b1, "R6 set wins over ack", d[1], 1);
      wr(2'd1, 8'h03);

      // R2 disabled: frozen count, no flags, no watchdog
      wr(2'd0, 8'h18);
      wr(2'd1, 8'h03);
      p0 = wd_pulses;
      rd(2'd2, c0);
      repeat (600) @(negedge clk);
      rd(2'd2, c1);
      check(c1 == c0, "R2 count frozen", c1, c0);
      rd(2'd1, d); check(d == 8'h00, "R2 no flags", d, 0);
      check(irq == 1'b0, "R2 irq quiet", irq, 0);
      check(wd_pulses == p0, "R2 no watchdog", wd_pulses - p0, 0);
      wr(2'd0, 8'h01);
      repeat (10) @(negedge clk);
      rd(2'd2, d);
      check(d == 8'(int'(c0) + 10), "R2 resume", d, (int'(c0) + 10) % 256);

      // R7 / R8 watchdog timing at every rate
      for (int s = 0; s < 4; s++) begin
         per = 1 << (TB + s + 1);
         @(negedge clk);
         wr(2'd0, 8'(1 | (s << 1)));
         rd(2'd2, d); c = d;
         cyc0 = cyc;
         wr(2'd1, 8'h04);
         vabs = ((c + 1) / per + 4) * per;
         found = 1'b0;
         for (int i = 0; i < 2000 && !found; i++) begin
            if (wdog_rst) found = 1'b1;
            else @(negedge clk);
         end
         rd(2'd2, d);
         check(found && (cyc - cyc0) == (vabs - c), "R7 watchdog delay", cyc - cyc0, vabs - c);
         check(d == 8'(vabs % 256), "R7 watchdog count", d, vabs % 256);
         @(negedge clk);
         check(wdog_rst == 1'b0, "R7 one-cycle pulse", wdog_rst, 0);
      end

      // R8 regular restarts keep the watchdog quiet
      @(negedge clk);
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h04);
      p0 = wd_pulses;
      for (int i = 0; i < 10; i++) begin
         repeat (60) @(negedge clk);
         wr(2'd1, 8'h04);
      end
      check(wd_pulses == p0, "R8 restarted watchdog silent", wd_pulses - p0, 0);

      finish_test();
   end

   int per_list[5] = '{1, 5, 37, 200, 256};

endmodule